// File: doc/BRIEF.md
# Peripheral Handshake Output Controller

This block drives one dual-purpose peripheral control line while that line is configured as an output. A three-bit mode field selects the behaviour. The top bit turns output operation on. The two lower bits choose between an interlocked handshake, a one-cycle strobe, and a fixed low or fixed high level. In handshake mode the processor's access to port data takes the line low, and an active edge reported on the companion input takes it high again. The peripheral and the processor can therefore pace each transfer against each other.

A parameter picks the side the block serves. In the read-side variant the line reacts to processor reads of port data, and it changes on the first clock edge after the access. In the write-side variant the line reacts to processor writes. There, the access and the companion edge both pass through one register stage first, so the line changes one clock later, after the next enable edge. The access strobe and the companion edge are single-cycle pulses from the surrounding bus decode and edge detect logic. Polarity selection and interrupt flags are handled outside this block.

Top module: `hsk_ctrl_line`

## Requirements
- R1: After reset the line output is 1.
- R2: `line_oe` equals `mode_bits[2]`. While `mode_bits[2]` is 0, the line is driven to 1 at every clock edge.
- R3: With `mode_bits` = 3'b110 the line is 0, and with 3'b111 it is 1, from the first clock edge after the field is applied.
- R4: With `mode_bits` = 3'b100 (handshake), an access takes the line to 0 and a companion edge takes it to 1. With neither present, the line holds its level.
- R5: In handshake mode, an access and a companion edge presented in the same cycle take the line to 0.
- R6: With `mode_bits` = 3'b101 (strobe), each access makes the line 0 for exactly one clock. Otherwise the line is 1, and companion edges have no effect.
- R7: Latency. When WRITE_SIDE=0, an event presented in cycle n acts at clock edge n+1. When WRITE_SIDE=1, it acts at edge n+2, using the mode field present at that edge.
- R8: Accesses and companion edges presented in input mode or in either fixed-level mode are discarded. They do not change the line, and they do not act later after a switch to handshake or strobe mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_bits | input | 3 | [2] output enable; [1:0] 00 handshake, 01 strobe, 10 fixed low, 11 fixed high |
| port_access | input | 1 | One-cycle pulse: processor read (read side) or write (write side) of port data |
| peer_edge | input | 1 | One-cycle pulse: active edge detected on the companion input |
| line_out | output | 1 | Control line level |
| line_oe | output | 1 | Control line output enable |

## Verification
The bench applies one stimulus sequence to a read-side instance and a write-side instance at the same time. Each cycle it compares both lines against their own expected latency, which separates a one-stage response from a two-stage response. The handshake is tried with a lone access, a lone edge, idle cycles, and an access and an edge together, starting from both high and low levels. These patterns separate set, clear, hold and the rule that the access wins. The strobe mode is tried with an access followed by idle cycles and with an edge alone, which checks that the low pulse lasts exactly one clock. Strobes presented in input and fixed-level modes, followed by a switch to handshake, show whether discarded events leak into a later mode.

// File: rtl/hsk_pkg.sv
// Shared types for the handshake output controller.
// Assumes the mode field layout: [2] output enable, [1:0] mode select.
package hsk_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        MODE_HSK   = 2'b00,
        MODE_PULSE = 2'b01,
        MODE_LOW   = 2'b10,
        MODE_HIGH  = 2'b11
    } out_mode_e;
endpackage

// File: rtl/hsk_mode_decode.sv
// Splits the mode field into an output enable, a mode enum, and an event
// enable flag. The flag is high only in handshake or strobe output modes.
// Assumes the field is stable or changes only between clock edges.
module hsk_mode_decode
    import hsk_pkg::*;
(
    input  logic [MODE_W-1:0] mode_bits,
    output logic              out_en,
    output out_mode_e         mode,
    output logic              evt_active
);
    // Decode the field into its parts.
    always_comb begin
        out_en     = mode_bits[MODE_W-1];
        mode       = out_mode_e'(mode_bits[MODE_W-2:0]);
        evt_active = out_en && !mode_bits[MODE_W-2];
    end
endmodule

// File: rtl/hsk_event_align.sv
// Delays the access and edge events by STAGES clocks, as the write side
// needs. Events are captured only while evt_active is high, so events seen
// in other modes are dropped at the input. Assumes STAGES >= 1.
module hsk_event_align #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_active,
    input  logic acc_in,
    input  logic edg_in,
    output logic acc_out,
    output logic edg_out
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] acc_sr;
    logic [STAGES-1:0] edg_sr;

    // Shift the masked events through the delay chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_sr <= '0;
            edg_sr <= '0;
        end else begin
            acc_sr[0] <= acc_in && evt_active;
            edg_sr[0] <= edg_in && evt_active;
            for (int i = 1; i < STAGES; i++) begin
                acc_sr[i] <= acc_sr[i-1];
                edg_sr[i] <= edg_sr[i-1];
            end
        end
    end

    assign acc_out = acc_sr[LAST];
    assign edg_out = edg_sr[LAST];
endmodule

// File: rtl/hsk_line_fsm.sv
// Holds the line register and computes its next level from the current
// mode and the aligned events. An access takes priority over an edge.
// Assumes events arrive already aligned to the mode that applies to them.
module hsk_line_fsm
    import hsk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      out_en,
    input  out_mode_e mode,
    input  logic      acc,
    input  logic      edg,
    output logic      line_q
);
    logic line_d;

    // Select the next line level for the current mode.
    always_comb begin
        line_d = line_q;
        if (!out_en) begin
            line_d = 1'b1;
        end else begin
            unique case (mode)
                MODE_HSK: begin
                    if (acc)      line_d = 1'b0;
                    else if (edg) line_d = 1'b1;
                end
                MODE_PULSE: line_d = !acc;
                MODE_LOW:   line_d = 1'b0;
                MODE_HIGH:  line_d = 1'b1;
                default:    line_d = 1'b1;
            endcase
        end
    end

    // Register the line level; it resets high.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_d;
    end
endmodule

// File: rtl/hsk_ctrl_line.sv
// Top of the handshake output controller. WRITE_SIDE=0 reacts to reads of
// port data one clock after the access. WRITE_SIDE=1 reacts to writes and
// adds one alignment stage. Assumes access and edge are one-cycle pulses.
module hsk_ctrl_line
    import hsk_pkg::*;
#(
    parameter bit WRITE_SIDE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_bits,
    input  logic              port_access,
    input  logic              peer_edge,
    output logic              line_out,
    output logic              line_oe
);
    localparam int ALIGN_STAGES = WRITE_SIDE ? 1 : 0;

    logic      out_en;
    logic      evt_active;
    out_mode_e mode;
    logic      acc_al;
    logic      edg_al;

    hsk_mode_decode u_dec (
        .mode_bits  (mode_bits),
        .out_en     (out_en),
        .mode       (mode),
        .evt_active (evt_active)
    );

    generate
        if (ALIGN_STAGES > 0) begin : g_align
            hsk_event_align #(.STAGES(ALIGN_STAGES)) u_align (
                .clk        (clk),
                .rst_n      (rst_n),
                .evt_active (evt_active),
                .acc_in     (port_access),
                .edg_in     (peer_edge),
                .acc_out    (acc_al),
                .edg_out    (edg_al)
            );
        end else begin : g_direct
            // Pass the events straight through, gated by the mode.
            always_comb begin
                acc_al = port_access && evt_active;
                edg_al = peer_edge && evt_active;
            end
        end
    endgenerate

    hsk_line_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .out_en (out_en),
        .mode   (mode),
        .acc    (acc_al),
        .edg    (edg_al),
        .line_q (line_out)
    );

    assign line_oe = out_en;
endmodule

// File: rtl/hsk_ctrl_line_chk.sv
// Checker for hsk_ctrl_line. It sees only the ports and relates the mode
// field and the events to the line level over time, for either variant.
module hsk_ctrl_line_chk #(
    parameter bit WRITE_SIDE = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_bits,
    input logic       port_access,
    input logic       peer_edge,
    input logic       line_out,
    input logic       line_oe
);
    logic hs;
    logic pl;
    assign hs = (mode_bits == 3'b100);
    assign pl = (mode_bits == 3'b101);

    // R2
    input_mode_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |=> line_out);

    // R3
    manual_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == 3'b110) |=> !line_out);

    // R3
    manual_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == 3'b111) |=> line_out);

    generate
        if (!WRITE_SIDE) begin : g_rd
            // R4 R7
            hsk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hs && port_access) |=> !line_out);
            // R4 R7
            hsk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hs && peer_edge && !port_access) |=> line_out);
            // R4
            hsk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hs && !peer_edge && !port_access) |=> $stable(line_out));
            // R5
            hsk_coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hs && peer_edge && port_access) |=> !line_out);
            // R6
            pulse_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pl && !port_access) |=> line_out);
        end else begin : g_wr
            // R4 R7
            hsk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hs && port_access) ##1 hs |=> !line_out);
            // R4 R7
            hsk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hs && peer_edge && !port_access) ##1 hs |=> line_out);
            // R4
            hsk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hs && !peer_edge && !port_access) ##1 hs |=> $stable(line_out));
            // R5
            hsk_coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hs && peer_edge && port_access) ##1 hs |=> !line_out);
            // R6
            pulse_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pl && !port_access) ##1 pl |=> line_out);
        end
    endgenerate
endmodule

bind hsk_ctrl_line hsk_ctrl_line_chk #(.WRITE_SIDE(WRITE_SIDE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_bits   (mode_bits),
    .port_access (port_access),
    .peer_edge   (peer_edge),
    .line_out    (line_out),
    .line_oe     (line_oe)
);

// File: tb/hsk_ctrl_line_tb.sv
// Directed bench: one stimulus stream drives a read-side and a write-side
// instance; each scenario task checks both lines every cycle.
module hsk_ctrl_line_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_bits = 3'b000;
    logic       port_access = 1'b0;
    logic       peer_edge = 1'b0;
    logic       line_r, oe_r, line_w, oe_w;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsk_ctrl_line #(.WRITE_SIDE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_bits(mode_bits),
        .port_access(port_access), .peer_edge(peer_edge),
        .line_out(line_r), .line_oe(oe_r)
    );

    hsk_ctrl_line #(.WRITE_SIDE(1'b1)) u_dut_w (
        .clk(clk), .rst_n(rst_n), .mode_bits(mode_bits),
        .port_access(port_access), .peer_edge(peer_edge),
        .line_out(line_w), .line_oe(oe_w)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", what, act, exp);
        end
    endtask

    // Present events for one cycle, then check both lines after the edge.
    task automatic tick(input logic acc, input logic edg,
                        input logic exp_r, input logic exp_w, input string req);
        port_access = acc;
        peer_edge   = edg;
        @(posedge clk);
        #1;
        port_access = 1'b0;
        peer_edge   = 1'b0;
        check(line_r, exp_r, {req, " read-side line"});
        check(line_w, exp_w, {req, " write-side line"});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check(line_r, 1'b1, "R1 reset read-side");
        check(line_w, 1'b1, "R1 reset write-side");
        check(oe_r, 1'b0, "R2 oe off in input mode");
    endtask

    task automatic t_input_mode();
        mode_bits = 3'b000;
        tick(1'b1, 1'b1, 1'b1, 1'b1, "R2 R8 input mode");
        tick(1'b0, 1'b0, 1'b1, 1'b1, "R2 R8 input mode after");
        check(oe_w, 1'b0, "R2 oe off");
    endtask

    task automatic t_manual();
        mode_bits = 3'b110;
        tick(1'b0, 1'b0, 1'b0, 1'b0, "R3 fixed low");
        check(oe_r, 1'b1, "R2 oe on");
        mode_bits = 3'b111;
        tick(1'b1, 1'b0, 1'b1, 1'b1, "R3 R8 fixed high");
    endtask

    task automatic t_handshake();
        mode_bits = 3'b100;
        tick(1'b0, 1'b0, 1'b1, 1'b1, "R8 no leak into handshake");
        tick(1'b1, 1'b0, 1'b0, 1'b1, "R4 R7 access clears");
        tick(1'b0, 1'b0, 1'b0, 1'b0, "R4 R7 write-side clears late");
        tick(1'b0, 1'b1, 1'b1, 1'b0, "R4 R7 edge sets");
        tick(1'b0, 1'b0, 1'b1, 1'b1, "R4 R7 write-side sets late");
        tick(1'b0, 1'b0, 1'b1, 1'b1, "R4 hold");
    endtask

    task automatic t_coincide();
        mode_bits = 3'b100;
        tick(1'b1, 1'b1, 1'b0, 1'b1, "R5 coincide from high");
        tick(1'b0, 1'b0, 1'b0, 1'b0, "R5 coincide write-side");
        tick(1'b1, 1'b1, 1'b0, 1'b0, "R5 coincide from low");
        tick(1'b0, 1'b0, 1'b0, 1'b0, "R5 coincide from low write-side");
    endtask

    task automatic t_pulse();
        mode_bits = 3'b101;
        tick(1'b0, 1'b0, 1'b1, 1'b1, "R6 strobe idle high");
        tick(1'b1, 1'b0, 1'b0, 1'b1, "R6 R7 strobe low");
        tick(1'b0, 1'b0, 1'b1, 1'b0, "R6 R7 strobe one cycle");
        tick(1'b0, 1'b0, 1'b1, 1'b1, "R6 strobe returns high");
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R6 edge ignored in strobe");
        tick(1'b0, 1'b0, 1'b1, 1'b1, "R6 edge ignored after");
    endtask

    task automatic t_ignore();
        mode_bits = 3'b110;
        tick(1'b1, 1'b1, 1'b0, 1'b0, "R8 fixed low ignores events");
        tick(1'b0, 1'b0, 1'b0, 1'b0, "R8 fixed low after events");
        mode_bits = 3'b000;
        tick(1'b1, 1'b0, 1'b1, 1'b1, "R2 input mode returns high");
        check(oe_r, 1'b0, "R2 oe off again");
    endtask

    initial begin : watchdog
        while (cycles < MAX_CYCLES) begin
            @(posedge clk);
            cycles++;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_input_mode();
        t_manual();
        t_handshake();
        t_coincide();
        t_pulse();
        t_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule